// File: doc/BRIEF.md
# EDO DRAM Data-Bus Drive and Write-Commit Control

This block is the device-side decision logic of an extended-data-out DRAM. It runs on a fast sampling clock and watches the four active-low strobes: row strobe, column strobe, write enable and output enable. From them it decides three things. The first is when the 4-bit data bus is driven with read data and when it floats. The second is whether a write cycle is actually committed to the array. The third is whether the driven value comes from the output latch that holds data through column precharge. The memory array and the data path are not part of this block. Analog delays are replaced by minimum run lengths counted in sampling clocks.

Read data stays on the bus after the column strobe rises, as long as the row strobe and output enable stay low and write enable stays high. Raising output enable turns the bus off. Output enable can also be used to keep the bus off until the next column-strobe fall, in one of two ways. In the first, it is already high at the column-strobe rise and is held long enough. In the second, it is pulsed high for long enough during column-strobe high time. A write-enable low pulse in column-strobe high time turns the bus off, and a long enough pulse keeps it off until a read cycle starts. The block has no data stream of its own: every pin is a plain level, and no valid/ready handshake or back-pressure applies.

Top module: `edo_dq_ctrl`

## Requirements
- R1: While reset is asserted, and on the first sample after it, the drive enable, the commit strobe and the latch select are all 0.
- R2: A sampled column-strobe fall with the row strobe low and write enable high starts a read. The drive enable is 1 after that edge if output enable is low and no disable applies.
- R3: After a read, the drive enable stays 1 across the column-strobe rise and through precharge while the row strobe and output enable stay low and write enable stays high.
- R4: A sample with output enable high gives drive enable 0 after that edge. A later sample with output enable low restores the drive, unless a sticky disable is set.
- R5: If output enable is high at the sample where the column strobe rises and stays high for OE_HOLD_MIN consecutive samples (the rise sample included), the drive stays off until the next column-strobe fall. A shorter hold does not set this disable.
- R6: If output enable was low at the column-strobe rise, a high pulse of at least OE_PULSE_MIN samples during column-strobe high time keeps the drive off until the next column-strobe fall. A shorter pulse does not.
- R7: With the row and column strobes both high for OFF_DLY consecutive samples, the read ends and the drive enable goes to 0 on that sample. It stays driven during the shorter run before it.
- R8: A write-enable low sample outside a column-strobe-low/output-enable-low window turns the drive off. A run of at least WE_PULSE_MIN low samples keeps it off until a column-strobe fall with write enable high. A shorter run does not.
- R9: A column-strobe fall with the row strobe and write enable low is an early write. It gives a one-cycle commit strobe, and the drive stays off whatever output enable does.
- R10: A write-enable fall while the column and row strobes are low commits a late write (one-cycle strobe, read ends) only when output enable is high. With output enable low, nothing is committed and read data stays driven.
- R11: Every sampled column-strobe fall clears the sticky disable, so a new read drives again.
- R12: The latch select is 1 exactly when the drive enable is 1 and the column strobe was high at the same sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| dq_oe | output | 1 | Data bus drive enable (0 = High-Z) |
| wr_commit | output | 1 | One-cycle strobe: write committed to the array |
| dq_hold | output | 1 | Drive comes from the precharge output latch |

## Verification
Every output is registered once from the pins sampled at a rising edge, so each result is due exactly one clock after the edge that saw the stimulus. The minimum-width rules add the run length in samples on top of that. The bench changes pins only on falling edges. It updates its own cycle model with the same values, and compares all three outputs at the following falling edge. It therefore always samples one full register stage after the stimulus and never at an edge. Directed sequences place pulses one sample short of and exactly at each minimum width. Seeded random strobe traffic then exercises the interactions.

// File: rtl/edo_dq_pkg.sv
package edo_dq_pkg;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic oe_n;
  } edo_pins_t;

  typedef struct packed {
    logic cas_fall;
    logic cas_rise;
    logic we_fall;
  } edo_edges_t;

  localparam int RUN_OE   = 0;
  localparam int RUN_WE   = 1;
  localparam int RUN_OFF  = 2;
  localparam int NUM_RUNS = 3;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/edo_pin_edges.sv
module edo_pin_edges
  import edo_dq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cas_n,
  input  logic       we_n,
  output edo_edges_t edges
);

  logic cas_q;
  logic we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cas_q <= 1'b1;
      we_q  <= 1'b1;
    end else begin
      cas_q <= cas_n;
      we_q  <= we_n;
    end
  end

  assign edges.cas_fall = cas_q & ~cas_n;
  assign edges.cas_rise = ~cas_q & cas_n;
  assign edges.we_fall  = we_q & ~we_n;

endmodule

// File: rtl/edo_run_cnt.sv
module edo_run_cnt #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic [CW-1:0] cnt_nxt
);

  logic [CW-1:0] cnt_q;

  always_comb begin
    if (!run)        cnt_nxt = '0;
    else if (&cnt_q) cnt_nxt = cnt_q;
    else             cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

endmodule

// File: rtl/edo_dq_state.sv
module edo_dq_state
  import edo_dq_pkg::*;
#(
  parameter int OE_HOLD_MIN  = 2,
  parameter int OE_PULSE_MIN = 3,
  parameter int WE_PULSE_MIN = 2,
  parameter int OFF_DLY      = 2,
  parameter int CW           = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  edo_pins_t     pins,
  input  edo_edges_t    edges,
  input  logic [CW-1:0] oe_run,
  input  logic [CW-1:0] we_run,
  input  logic [CW-1:0] off_run,
  output logic          dq_oe,
  output logic          wr_commit,
  output logic          dq_hold
);

  localparam logic [CW-1:0] HOLD_T  = CW'(OE_HOLD_MIN);
  localparam logic [CW-1:0] PULSE_T = CW'(OE_PULSE_MIN);
  localparam logic [CW-1:0] WE_T    = CW'(WE_PULSE_MIN);
  localparam logic [CW-1:0] OFF_T   = CW'(OFF_DLY);

  logic          rd_q, rd_d;
  logic          blk_q, blk_d;
  logic          rise_q, rise_d;
  logic          commit_d, drive_d, we_gate, oe_qual, we_qual;
  logic [CW-1:0] oe_thr;

  always_comb begin
    // which OE-disable rule applies: run that began at the CAS rise or a later pulse
    rise_d = rise_q;
    if (edges.cas_rise)  rise_d = pins.oe_n;
    else if (!pins.oe_n) rise_d = 1'b0;
    oe_thr  = rise_d ? HOLD_T : PULSE_T;
    oe_qual = pins.cas_n && (oe_run >= oe_thr);
    we_qual = (we_run >= WE_T) && !(!pins.cas_n && !pins.oe_n);

    rd_d     = rd_q;
    commit_d = 1'b0;
    if (off_run >= OFF_T) rd_d = 1'b0;
    if (edges.cas_fall && !pins.ras_n) begin
      rd_d     = pins.we_n;
      commit_d = !pins.we_n;
    end else if (edges.we_fall && !pins.cas_n && !pins.ras_n && pins.oe_n) begin
      rd_d     = 1'b0;
      commit_d = 1'b1;
    end

    blk_d = blk_q;
    if (edges.cas_fall)          blk_d = 1'b0;
    else if (oe_qual || we_qual) blk_d = 1'b1;

    we_gate = pins.we_n || (!pins.cas_n && !pins.oe_n);
    drive_d = rd_d && !blk_d && !pins.oe_n && we_gate;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q      <= 1'b0;
      blk_q     <= 1'b0;
      rise_q    <= 1'b0;
      dq_oe     <= 1'b0;
      wr_commit <= 1'b0;
      dq_hold   <= 1'b0;
    end else begin
      rd_q      <= rd_d;
      blk_q     <= blk_d;
      rise_q    <= rise_d;
      dq_oe     <= drive_d;
      wr_commit <= commit_d;
      dq_hold   <= drive_d && pins.cas_n;
    end
  end

endmodule

// File: rtl/edo_dq_ctrl.sv
module edo_dq_ctrl
  import edo_dq_pkg::*;
#(
  parameter int OE_HOLD_MIN  = 2,
  parameter int OE_PULSE_MIN = 3,
  parameter int WE_PULSE_MIN = 2,
  parameter int OFF_DLY      = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic oe_n,
  output logic dq_oe,
  output logic wr_commit,
  output logic dq_hold
);

  localparam int MAXP = max_of4(OE_HOLD_MIN, OE_PULSE_MIN, WE_PULSE_MIN, OFF_DLY);
  localparam int CW   = $clog2(MAXP + 1) + 1;

  edo_pins_t     pins;
  edo_edges_t    edges;
  logic [NUM_RUNS-1:0] run_in;
  logic [CW-1:0] run_cnt [NUM_RUNS];

  assign pins = '{ras_n: ras_n, cas_n: cas_n, we_n: we_n, oe_n: oe_n};

  assign run_in[RUN_OE]  = oe_n & cas_n;
  assign run_in[RUN_WE]  = ~we_n;
  assign run_in[RUN_OFF] = ras_n & cas_n;

  edo_pin_edges u_edges (
    .clk   (clk),
    .rst_n (rst_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .edges (edges)
  );

  for (genvar g = 0; g < NUM_RUNS; g++) begin : g_run
    edo_run_cnt #(.CW(CW)) u_run (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_in[g]),
      .cnt_nxt (run_cnt[g])
    );
  end

  edo_dq_state #(
    .OE_HOLD_MIN  (OE_HOLD_MIN),
    .OE_PULSE_MIN (OE_PULSE_MIN),
    .WE_PULSE_MIN (WE_PULSE_MIN),
    .OFF_DLY      (OFF_DLY),
    .CW           (CW)
  ) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .pins      (pins),
    .edges     (edges),
    .oe_run    (run_cnt[RUN_OE]),
    .we_run    (run_cnt[RUN_WE]),
    .off_run   (run_cnt[RUN_OFF]),
    .dq_oe     (dq_oe),
    .wr_commit (wr_commit),
    .dq_hold   (dq_hold)
  );

endmodule

// File: rtl/edo_dq_ctrl_chk.sv
module edo_dq_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic oe_n,
  input logic dq_oe,
  input logic wr_commit,
  input logic dq_hold
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!dq_oe && !wr_commit && !dq_hold));

  assert_read_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !ras_n && we_n && !oe_n) |=> dq_oe);

  assert_oe_high_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |=> !dq_oe);

  assert_early_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !ras_n && !we_n) |=> (wr_commit && !dq_oe));

  assert_late_write_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(we_n) && !cas_n && $past(!cas_n) && !ras_n && !oe_n) |=> !wr_commit);

  assert_commit_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit);

  assert_hold_select_R12: assert property (@(posedge clk) disable iff (!rst_n)
    dq_hold |-> (dq_oe && $past(cas_n)));

endmodule

bind edo_dq_ctrl edo_dq_ctrl_chk u_chk (.*);

// File: tb/edo_dq_ctrl_tb.sv
`timescale 1ns/1ps
module edo_dq_ctrl_tb;

  localparam int P_HOLD  = 2;
  localparam int P_PULSE = 3;
  localparam int P_WE    = 2;
  localparam int P_OFF   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic dq_oe, wr_commit, dq_hold;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  // bench view of the requirements
  bit m_cas_prev = 1, m_we_prev = 1;
  int m_oe_high = 0, m_we_low = 0, m_both_high = 0;
  bit m_at_rise = 0, m_reading = 0, m_sticky = 0;
  bit e_oe = 0, e_commit = 0, e_hold = 0;

  always #2 clk = ~clk;

  edo_dq_ctrl #(
    .OE_HOLD_MIN (P_HOLD), .OE_PULSE_MIN (P_PULSE),
    .WE_PULSE_MIN(P_WE),   .OFF_DLY     (P_OFF)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .dq_oe(dq_oe), .wr_commit(wr_commit), .dq_hold(dq_hold)
  );

  function automatic bit sticky_sets(bit c, bit o);
    int need;
    need = m_at_rise ? P_HOLD : P_PULSE;                     // R5 / R6
    if (c && m_oe_high >= need) return 1;
    if (m_we_low >= P_WE && !(!c && !o)) return 1;           // R8
    return 0;
  endfunction

  task automatic predict(input bit r, input bit c, input bit w, input bit o);
    bit c_fell, c_rose, w_fell;
    c_fell = m_cas_prev && !c;
    c_rose = !m_cas_prev && c;
    w_fell = m_we_prev && !w;
    m_oe_high   = (o && c) ? m_oe_high + 1 : 0;
    m_we_low    = !w ? m_we_low + 1 : 0;
    m_both_high = (r && c) ? m_both_high + 1 : 0;
    if (c_rose) m_at_rise = o;
    else if (!o) m_at_rise = 0;
    e_commit = 0;
    if (m_both_high >= P_OFF) m_reading = 0;                 // R7
    if (c_fell && !r) begin
      m_reading = w;                                         // R2
      e_commit  = !w;                                        // R9
    end else if (w_fell && !c && !r && o) begin
      m_reading = 0;                                         // R10
      e_commit  = 1;
    end
    if (c_fell) m_sticky = 0;                                // R11
    else if (sticky_sets(c, o)) m_sticky = 1;
    e_oe   = m_reading && !m_sticky && !o && (w || (!c && !o));
    e_hold = e_oe && c;                                      // R12
    m_cas_prev = c;
    m_we_prev  = w;
  endtask

  task automatic step(input bit r, input bit c, input bit w, input bit o, input string tag);
    ras_n = r; cas_n = c; we_n = w; oe_n = o;
    predict(r, c, w, o);
    @(posedge clk);
    @(negedge clk);
    n_checks++;
    if (dq_oe !== e_oe || wr_commit !== e_commit || dq_hold !== e_hold) begin
      n_fails++;
      $display("FAIL %s: oe/commit/hold actual %b%b%b expected %b%b%b",
               tag, dq_oe, wr_commit, dq_hold, e_oe, e_commit, e_hold);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    n_checks++;
    if (dq_oe !== 1'b0 || wr_commit !== 1'b0 || dq_hold !== 1'b0) begin
      n_fails++;
      $display("FAIL R1: actual %b%b%b expected 000", dq_oe, wr_commit, dq_hold);
    end
    rst_n = 1'b1;
    step(1,1,1,1,"R1"); step(1,1,1,1,"R1");
    // read and extended hold
    step(0,1,1,0,"R2"); step(0,0,1,0,"R2");
    step(0,1,1,0,"R3"); step(0,1,1,0,"R3 R12");
    // OE toggle and pulse widths
    step(0,1,1,1,"R4"); step(0,1,1,0,"R4");
    step(0,1,1,1,"R6"); step(0,1,1,1,"R6"); step(0,1,1,0,"R6 short");
    step(0,1,1,1,"R6"); step(0,1,1,1,"R6"); step(0,1,1,1,"R6");
    step(0,1,1,0,"R6 sticky"); step(0,1,1,0,"R6 sticky");
    step(0,0,1,0,"R11");
    // OE high across the CAS rise
    step(0,0,1,1,"R4"); step(0,1,1,1,"R5"); step(0,1,1,0,"R5 short");
    step(0,0,1,1,"R5"); step(0,1,1,1,"R5"); step(0,1,1,1,"R5");
    step(0,1,1,0,"R5 sticky"); step(0,0,1,0,"R11");
    // WE in CAS high time
    step(0,1,1,0,"R3"); step(0,1,0,0,"R8"); step(0,1,1,0,"R8 short");
    step(0,1,0,0,"R8"); step(0,1,0,0,"R8"); step(0,1,1,0,"R8 sticky");
    step(0,0,0,0,"R9"); step(0,1,0,0,"R8"); step(0,1,1,0,"R8 sticky");
    step(0,0,1,0,"R8 R11");
    // late writes
    step(0,0,0,0,"R10 suppressed"); step(0,1,1,0,"R3");
    step(0,0,1,0,"R2"); step(0,0,1,1,"R4"); step(0,0,0,1,"R10 commit");
    step(0,0,1,1,"R10"); step(0,1,1,0,"R10");
    // early write together with CAS fall, OE low
    step(0,0,0,0,"R9"); step(0,1,1,0,"R9");
    // RAS and CAS both high
    step(0,0,1,0,"R2"); step(0,1,1,0,"R3"); step(1,1,1,0,"R7"); step(1,1,1,0,"R7");
    step(1,1,1,0,"R7");
    // seeded random strobe traffic
    begin
      bit r, c, w, o;
      r = 0; c = 1; w = 1; o = 0;
      for (int i = 0; i < 4000; i++) begin
        if ($urandom_range(15) == 0) r = ~r;
        if ($urandom_range(2) == 0)  c = ~c;
        if ($urandom_range(4) == 0)  w = ~w;
        if ($urandom_range(3) == 0)  o = ~o;
        step(r, c, w, o, "R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12 random");
      end
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule